// File: doc/BRIEF.md
# Quad-Channel Double-Rank Converter Register Front End

This block is the digital register stage in front of a four-channel digital-to-analog converter. A host presents a data word, a two-bit channel address, an active-low select and an active-low write strobe. When the strobe returns high while the select is held low, the word is stored in the staging register of the addressed channel. Staging registers do not drive the converters. A separate active-low load control copies every staging register into its output register on the same clock edge, so all four converter codes change together.

An asynchronous active-low clear and a power-on reset both put every staging and output register at zero. The clear takes priority over any write or load. The block also passes two settings through to the analog side: a power-down flag, taken from an active-low pin and presented active high, and a range-doubling flag. Neither setting changes any stored code. The data width is a parameter, because some variants of the converter take 10-bit codes and others take 12-bit codes.

The parallel port has no valid/ready handshake and no back-pressure. Every qualified strobe edge is accepted on the clock edge where it is seen, so the host only has to keep the address and data steady through that edge. All inputs except the clear and the reset are sampled on `clk`.

Top module: `quad_dac_front`

## Requirements
- R1: A write takes place only on a clock edge where `wr_n` is sampled high, `wr_n` was sampled low on the edge before, and `cs_n` is sampled low. On that edge `din` goes into the addressed staging register. A strobe with `cs_n` high changes nothing.
- R2: Address value k (0 to 3, with `addr[1]` as the MSB) selects channel k. The output register of channel k is presented on `dac_data[k*DATA_W +: DATA_W]`, so channel 0 occupies the lowest bits.
- R3: While `load_n` is sampled high, writes change only staging registers, and `dac_data` holds its value.
- R4: On every clock edge where `load_n` is sampled low, every output register takes the value of its staging register, so all channels update on the same edge.
- R5: If `load_n` is sampled low on the same edge as a write, the written channel's output register takes the new `din` value on that edge.
- R6: While `clr_n` is low, all staging and output registers are zero at once, without waiting for a clock edge. Writes and loads during that time have no effect, and the staging registers still read as zero after `clr_n` is released.
- R7: A low `rst_n` produces the same all-zero state as `clr_n`, asynchronously.
- R8: `powerdown` is 1 exactly when `pd_n` is 0. Entering and leaving power-down does not change `dac_data`.
- R9: `range_x2` follows `gain`.
- R10: Codes of the full `DATA_W` width, including all ones, are stored and presented without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| clr_n | input | 1 | Register clear, asynchronous, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; data is captured on its rising edge |
| addr | input | 2 | Channel address (1 is the MSB) |
| din | input | DATA_W | Parallel code |
| load_n | input | 1 | Copies all staging registers to output registers, active low |
| pd_n | input | 1 | Power-down request, active low |
| gain | input | 1 | Range select: 1 doubles the output span |
| dac_data | output | 4*DATA_W | Output register codes, channel 0 in the low bits |
| powerdown | output | 1 | Power-down flag, active high |
| range_x2 | output | 1 | Range-doubling flag |

## Verification
Four distinct codes are written to the four addresses with load held off and then loaded together. This shows address decode and slice placement, and it separates the staging rank from the output rank. A strobe with select high is followed by a load, which shows that the write was dropped. A write with load held low, made while another channel's staging and output values differ, separates the pass-through of new data from the plain copy. The bench also tries writes and loads while clear is held, an all-ones code, and power-down toggling, and compares each against the expected register image.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  // Channel count is fixed by the two address pins.
  localparam int CH_COUNT = 4;
  localparam int CH_SEL_W = $clog2(CH_COUNT);

  typedef enum logic [CH_SEL_W-1:0] {
    CH_A = 2'd0,
    CH_B = 2'd1,
    CH_C = 2'd2,
    CH_D = 2'd3
  } ch_id_e;
endpackage

// File: rtl/dfe_strobe.sv
module dfe_strobe
  import dfe_pkg::*;
(
  input  logic                clk,
  input  logic                arst_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic [CH_SEL_W-1:0] addr,
  output logic [CH_COUNT-1:0] wr_sel
);
  // Previous sample of the write strobe; idle high.
  logic wr_n_q;
  logic fire;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) wr_n_q <= 1'b1;
    else         wr_n_q <= wr_n;
  end

  // Rising strobe edge qualified by chip select.
  assign fire = !cs_n && !wr_n_q && wr_n;

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_dec
    assign wr_sel[g] = fire && (addr == CH_SEL_W'(g));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(wr_sel)); // R2
  AST_NO_WR_DESELECTED: assert property (@(posedge clk) disable iff (!arst_n)
    cs_n |-> (wr_sel == '0)); // R1
endmodule

// File: rtl/dfe_channel.sv
module dfe_channel #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic              load_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dac_q
);
  logic [DATA_W-1:0] stage_q;

  // Staging rank.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    stage_q <= '0;
    else if (wr_en) stage_q <= din;
  end

  // Output rank: a load copies the staging value, or the incoming word
  // when a write lands on the same edge.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      dac_q <= '0;
    else if (!load_n) dac_q <= wr_en ? din : stage_q;
  end

  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en |=> (stage_q == $past(din))); // R1
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    load_n |=> $stable(dac_q)); // R3
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!arst_n)
    (!load_n && !wr_en) |=> (dac_q == $past(stage_q))); // R4
  AST_LOAD_THROUGH: assert property (@(posedge clk) disable iff (!arst_n)
    (!load_n && wr_en) |=> (dac_q == $past(din))); // R5
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
  import dfe_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_n,
  input  logic                       cs_n,
  input  logic                       wr_n,
  input  logic [CH_SEL_W-1:0]        addr,
  input  logic [DATA_W-1:0]          din,
  input  logic                       load_n,
  input  logic                       pd_n,
  input  logic                       gain,
  output logic [CH_COUNT*DATA_W-1:0] dac_data,
  output logic                       powerdown,
  output logic                       range_x2
);
  localparam int BUS_W = CH_COUNT * DATA_W;

  // Clear and power-on reset share one asynchronous path.
  logic                arst_n;
  logic [CH_COUNT-1:0] wr_sel;

  assign arst_n = rst_n & clr_n;

  dfe_strobe u_strobe (
    .clk    (clk),
    .arst_n (arst_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .wr_sel (wr_sel)
  );

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
    dfe_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (clk),
      .arst_n (arst_n),
      .wr_en  (wr_sel[g]),
      .load_n (load_n),
      .din    (din),
      .dac_q  (dac_data[g*DATA_W +: DATA_W])
    );
  end

  // Analog-side settings pass straight through.
  assign powerdown = ~pd_n;
  assign range_x2  = gain;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_data == BUS_W'(0))); // R6
  AST_PD_KEEPS: assert property (@(posedge clk) disable iff (!arst_n)
    (load_n && $changed(pd_n)) |-> $stable(dac_data)); // R8
endmodule

// File: tb/quad_dac_front_tb_top.sv
module quad_dac_front_tb_top;
  localparam int W   = 10;
  localparam int NCH = 4;
  localparam int TOT = NCH * W;

  logic clk = 1'b0;
  logic rst_n, clr_n, cs_n, wr_n, load_n, pd_n, gain;
  logic [1:0]     addr;
  logic [W-1:0]   din;
  logic [TOT-1:0] dac_data;
  logic powerdown, range_x2;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0]   stage_m [NCH];
  logic [W-1:0]   dac_m   [NCH];
  logic [TOT-1:0] exp_q [$];
  string          tag_q [$];
  logic [TOT-1:0] mon_e;
  string          mon_t;

  always #2 clk = ~clk;

  quad_dac_front #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .din(din), .load_n(load_n), .pd_n(pd_n), .gain(gain),
    .dac_data(dac_data), .powerdown(powerdown), .range_x2(range_x2)
  );

  function automatic logic [TOT-1:0] image();
    logic [TOT-1:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i*W +: W] = dac_m[i];
    return v;
  endfunction

  task automatic model_zero();
    for (int i = 0; i < NCH; i++) begin
      stage_m[i] = '0;
      dac_m[i]   = '0;
    end
  endtask

  // Scoreboard push: compared just after the next rising edge.
  task automatic expect_img(input string tag);
    exp_q.push_back(image());
    tag_q.push_back(tag);
  endtask

  task automatic chk(input string tag, input logic [TOT-1:0] got, input logic [TOT-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops expectations after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        checks++;
        if (dac_data !== mon_e) begin
          fails++;
          $display("FAIL %s: dac_data %h expected %h", mon_t, dac_data, mon_e);
        end
      end
    end
  end

  // Strobe write; ld=0 holds load low on the capture edge.
  task automatic write_ch(input int ch, input logic [W-1:0] val,
                          input logic cs, input logic ld, input string tag);
    @(negedge clk);
    cs_n = cs; addr = 2'(ch); din = val; wr_n = 1'b0; load_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b1; load_n = ld;
    if (clr_n && !cs) stage_m[ch] = val;
    if (clr_n && !ld) for (int i = 0; i < NCH; i++) dac_m[i] = stage_m[i];
    expect_img(tag);
    @(negedge clk);
    cs_n = 1'b1; load_n = 1'b1; din = ~val;
  endtask

  task automatic load_all(input string tag);
    @(negedge clk);
    load_n = 1'b0;
    if (clr_n) for (int i = 0; i < NCH; i++) dac_m[i] = stage_m[i];
    expect_img(tag);
    @(negedge clk);
    load_n = 1'b1;
  endtask

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1; load_n = 1'b1;
    pd_n = 1'b1; gain = 1'b0; addr = '0; din = '0;
    model_zero();
    repeat (3) @(negedge clk);
    chk("R7 reset state", dac_data, '0);
    rst_n = 1'b1;

    // R3: staging writes leave outputs alone; R2 distinct code per address
    write_ch(0, 10'h011, 1'b0, 1'b1, "R3 hold ch0");
    write_ch(1, 10'h122, 1'b0, 1'b1, "R3 hold ch1");
    write_ch(2, 10'h233, 1'b0, 1'b1, "R3 hold ch2");
    write_ch(3, 10'h3FF, 1'b0, 1'b1, "R3 hold ch3");
    load_all("R2 R4 simultaneous load");
    chk("R2 channel 3 slice", TOT'(dac_data[3*W +: W]), TOT'(10'h3FF));

    // R1: deselected strobe dropped
    write_ch(2, 10'h055, 1'b1, 1'b1, "R1 deselected write");
    load_all("R1 load after deselected write");

    // R5: transparent write while ch3 staging differs from its output
    write_ch(3, 10'h001, 1'b0, 1'b1, "R3 stage ch3");
    write_ch(1, 10'h2AA, 1'b0, 1'b0, "R5 write with load low");

    // R10: full-width code
    write_ch(0, {W{1'b1}}, 1'b0, 1'b1, "R10 stage all ones");
    load_all("R10 all ones loaded");

    // R8: power-down flag, contents kept
    @(negedge clk);
    pd_n = 1'b0;
    #1 chk("R8 powerdown high", TOT'(powerdown), TOT'(1'b1));
    expect_img("R8 contents in power-down");
    repeat (3) @(negedge clk);
    pd_n = 1'b1;
    #1 chk("R8 powerdown low", TOT'(powerdown), TOT'(1'b0));
    expect_img("R8 contents after release");

    // R9: range flag
    @(negedge clk);
    gain = 1'b1;
    #1 chk("R9 range high", TOT'(range_x2), TOT'(1'b1));
    @(negedge clk);
    gain = 1'b0;
    #1 chk("R9 range low", TOT'(range_x2), TOT'(1'b0));

    // R6: asynchronous clear with priority
    write_ch(2, 10'h0F0, 1'b0, 1'b1, "R3 stage ch2");
    @(negedge clk);
    clr_n = 1'b0;
    model_zero();
    #1 chk("R6 async clear", dac_data, '0);
    write_ch(1, 10'h123, 1'b0, 1'b0, "R6 write and load during clear");
    @(negedge clk);
    clr_n = 1'b1;
    load_all("R6 staging cleared");
    write_ch(3, 10'h0AB, 1'b0, 1'b0, "R5 write after clear");

    // R7: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    model_zero();
    #1 chk("R7 async reset", dac_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    load_all("R7 staging reset");

    repeat (3) @(negedge clk);
    wait (exp_q.size() == 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule